// File: doc/BRIEF.md
# Fractional-Phase FIR Output Interpolator

This block produces one output audio sample whenever the output-rate side raises a request. It keeps a circular record of recent input samples, written at the input sample rate, and on each request it picks one sub-filter of a long low-pass prototype FIR. The pick is made from a fractional position between input samples, supplied from outside with each request. The output is the plain convolution of the 64 newest stored samples with that sub-filter's 64 coefficients. Because the position can take any value, output instants need not bear any fixed ratio to input instants.

The prototype has 64 × 256 points, so each of 256 phases owns 64 taps. A further 8 fraction bits are used to blend linearly between neighbouring phases. One multiply-accumulate is done per clock, so a result takes 64 cycles. A request that arrives during a computation is held and is started as soon as the running one ends. The coefficients are produced by arithmetic inside the design. No stored table is used.

Top module: `phase_interp`

## Requirements
- R1: Every output uses exactly the 64 newest input samples held at the moment its computation starts. Tap t is multiplied by the sample of age t, where age 0 is the newest and age 63 is the oldest. After reset, all stored samples read as zero.
- R2: The prototype coefficient at index n (0 ≤ n ≤ 16384) is n+1 when n < 8192, and 16384−n otherwise. For tap t and coarse phase p (out_phase bits 15:8), the base index is n = t·256 + p.
- R3: With fine fraction u (out_phase bits 7:0), the coefficient used for a tap is c(n) + floor((c(n+1) − c(n))·u / 256).
- R4: The result is S = Σ sample(age t)·coef(t). It is rounded as (S + 2^17) arithmetically shifted right by 18.
- R5: out_valid is a one-cycle pulse, 64 clock edges after the edge that accepts the request. out_sample keeps its value between pulses.
- R6: A request that arrives during a computation is held, together with the phase present at its arrival. It starts on the edge where the running computation ends, so its result follows exactly 64 cycles later. A further request while one is already held replaces the held phase.
- R7: Input samples written while a computation runs (up to 64 of them) do not change its result. A sample written on the same edge that accepts a request counts as that request's newest sample.
- R8: After reset, out_valid is 0 and out_sample is 0.
- R9: A rounded result above 8388607 is output as 8388607. A result below −8388608 is output as −8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Writes in_sample into the history on this edge |
| in_sample | input | 24 | Signed input sample |
| out_req | input | 1 | Request for one output sample |
| out_phase | input | 16 | Fractional position: bits 15:8 coarse phase, bits 7:0 fine blend |
| out_valid | output | 1 | One-cycle pulse when out_sample is new |
| out_sample | output | 24 | Signed, rounded and saturated result |

## Verification
The bench builds the block with its default parameters: 64 taps, 256 stored phases, 8 fine bits, 24-bit samples and 16-bit coefficients. With these values, full-scale constant inputs push the tap sum past unity gain, so both saturation limits can be reached. Phases at both ends of the coarse range, and the phase where the prototype peaks, are also in reach. The bench checks pending and replaced requests, and inputs written during a run, against an independent model of the coefficient formula and the history.

// File: rtl/phase_interp_pkg.sv
package phase_interp_pkg;
    localparam int DEF_DATA_W    = 24;
    localparam int DEF_TAPS      = 64;
    localparam int DEF_PH_BITS   = 8;
    localparam int DEF_FINE_BITS = 8;
    localparam int DEF_COEF_W    = 16;
    localparam int DEF_ACC_W     = 48;
    localparam int DEF_OUT_SHIFT = 18;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/phase_interp_hist.sv
module phase_interp_hist #(
    parameter int DATA_W   = 24,
    parameter int DEPTH    = 128,
    parameter int TAP_BITS = 6,
    localparam int PTR_W   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [PTR_W-1:0]         rd_base,
    input  logic [TAP_BITS-1:0]      rd_age,
    output logic [PTR_W-1:0]         newest_next,
    output logic signed [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [PTR_W-1:0]                newest;
        logic [DEPTH-1:0][DATA_W-1:0]    mem;
    } hist_t;

    hist_t h_d, h_q;
    logic [PTR_W-1:0] rd_idx;

    always_comb begin
        h_d = h_q;
        if (wr_en) begin
            h_d.newest = h_q.newest + PTR_W'(1);
            h_d.mem[h_d.newest] = wr_data;
        end
        newest_next = h_d.newest;
        rd_idx  = rd_base - {{(PTR_W-TAP_BITS){1'b0}}, rd_age};
        rd_data = $signed(h_q.mem[rd_idx]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // R7: each write moves the newest slot forward by exactly one
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (h_q.newest == $past(h_q.newest) + PTR_W'(1)))
        else $error("history pointer did not advance by one");
endmodule

// File: rtl/phase_interp_coef.sv
module phase_interp_coef #(
    parameter int TAPS      = 64,
    parameter int PH_BITS   = 8,
    parameter int FINE_BITS = 8,
    parameter int COEF_W    = 16,
    localparam int TAP_BITS = $clog2(TAPS),
    localparam int PHASE_W  = PH_BITS + FINE_BITS
) (
    input  logic [TAP_BITS-1:0]      tap,
    input  logic [PHASE_W-1:0]       phase,
    output logic signed [COEF_W-1:0] coef
);
    localparam int PROTO_LEN = TAPS << PH_BITS;
    localparam int HALF      = PROTO_LEN / 2;
    localparam int IDX_W     = TAP_BITS + PH_BITS + 1;
    localparam int CW        = COEF_W + 1;
    localparam int PW        = COEF_W + FINE_BITS + 2;

    // triangular prototype, one point per coarse phase step
    function automatic logic signed [CW-1:0] proto_at(input logic [IDX_W-1:0] n);
        logic [CW-1:0] ext;
        ext = {{(CW-IDX_W){1'b0}}, n};
        if (n < IDX_W'(HALF)) proto_at = $signed(ext + CW'(1));
        else                  proto_at = $signed(CW'(PROTO_LEN) - ext);
    endfunction

    logic [IDX_W-1:0]       n0, n1;
    logic signed [CW-1:0]   c0, c1, slope;
    logic signed [PW-1:0]   scaled, blended;

    always_comb begin
        n0      = {1'b0, tap, phase[PHASE_W-1:FINE_BITS]};
        n1      = n0 + IDX_W'(1);
        c0      = proto_at(n0);
        c1      = proto_at(n1);
        slope   = c1 - c0;
        scaled  = PW'(slope) * $signed({1'b0, phase[FINE_BITS-1:0]});
        blended = PW'(c0) + (scaled >>> FINE_BITS);
        coef    = COEF_W'(blended);
    end
endmodule

// File: rtl/phase_interp_mac.sv
module phase_interp_mac #(
    parameter int DATA_W    = 24,
    parameter int COEF_W    = 16,
    parameter int ACC_W     = 48,
    parameter int OUT_SHIFT = 18,
    parameter int TAPS      = 64,
    localparam int CNT_W    = $clog2(TAPS) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     acc_en,
    input  logic                     last,
    input  logic signed [DATA_W-1:0] sample,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_sample
);
    localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1) << (OUT_SHIFT - 1);
    localparam logic signed [ACC_W-1:0] OUT_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] OUT_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    valid;
        logic [DATA_W-1:0]       result;
    } mac_t;

    mac_t m_d, m_q;
    logic signed [DATA_W+COEF_W-1:0] prod;
    logic signed [ACC_W-1:0]         acc_sum, rnd, shifted;

    always_comb begin
        m_d       = m_q;
        m_d.valid = 1'b0;
        prod      = sample * coef;
        acc_sum   = m_q.acc + ACC_W'(prod);
        rnd       = acc_sum + RND;
        shifted   = rnd >>> OUT_SHIFT;
        if (acc_en) m_d.acc = acc_sum;
        if (clr)    m_d.acc = '0;
        if (acc_en && last) begin
            m_d.valid = 1'b1;
            if (shifted > OUT_MAX)      m_d.result = OUT_MAX[DATA_W-1:0];
            else if (shifted < OUT_MIN) m_d.result = OUT_MIN[DATA_W-1:0];
            else                        m_d.result = shifted[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign out_valid  = m_q.valid;
    assign out_sample = m_q.result;

    // checker: product terms gathered since the last clear
    logic [CNT_W-1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seen_q <= '0;
        else if (clr)    seen_q <= '0;
        else if (acc_en) seen_q <= seen_q + CNT_W'(1);
    end

    p_tap_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && last) |-> (seen_q == CNT_W'(TAPS - 1)))
        else $error("result formed from a wrong number of taps");

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid)
        else $error("out_valid longer than one cycle");

    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sample))
        else $error("out_sample changed without out_valid");

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> (acc_sum[ACC_W-1] == acc_sum[ACC_W-2]))
        else $error("accumulator headroom exhausted");
endmodule

// File: rtl/phase_interp.sv
module phase_interp
    import phase_interp_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int TAPS      = DEF_TAPS,
    parameter int PH_BITS   = DEF_PH_BITS,
    parameter int FINE_BITS = DEF_FINE_BITS,
    parameter int COEF_W    = DEF_COEF_W,
    parameter int ACC_W     = DEF_ACC_W,
    parameter int OUT_SHIFT = DEF_OUT_SHIFT,
    localparam int PHASE_W  = PH_BITS + FINE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_sample,
    input  logic               out_req,
    input  logic [PHASE_W-1:0] out_phase,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_sample
);
    localparam int TAP_BITS = $clog2(TAPS);
    localparam int DEPTH    = 2 * TAPS;
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int HALF     = (TAPS << PH_BITS) / 2;

    typedef struct packed {
        run_state_e          state;
        logic [TAP_BITS-1:0] tap;
        logic [PTR_W-1:0]    base;
        logic [PHASE_W-1:0]  phase;
        logic                pend;
        logic [PHASE_W-1:0]  pend_phase;
    } ctl_t;

    ctl_t s_d, s_q;
    logic                     clr, acc_en, last;
    logic [PTR_W-1:0]         newest_next;
    logic signed [DATA_W-1:0] tap_sample;
    logic signed [COEF_W-1:0] coef;

    phase_interp_hist #(
        .DATA_W   (DATA_W),
        .DEPTH    (DEPTH),
        .TAP_BITS (TAP_BITS)
    ) hist_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (in_valid),
        .wr_data     (in_sample),
        .rd_base     (s_q.base),
        .rd_age      (s_q.tap),
        .newest_next (newest_next),
        .rd_data     (tap_sample)
    );

    phase_interp_coef #(
        .TAPS      (TAPS),
        .PH_BITS   (PH_BITS),
        .FINE_BITS (FINE_BITS),
        .COEF_W    (COEF_W)
    ) coef_i (
        .tap   (s_q.tap),
        .phase (s_q.phase),
        .coef  (coef)
    );

    phase_interp_mac #(
        .DATA_W    (DATA_W),
        .COEF_W    (COEF_W),
        .ACC_W     (ACC_W),
        .OUT_SHIFT (OUT_SHIFT),
        .TAPS      (TAPS)
    ) mac_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .acc_en     (acc_en),
        .last       (last),
        .sample     (tap_sample),
        .coef       (coef),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always_comb begin
        s_d    = s_q;
        clr    = 1'b0;
        acc_en = 1'b0;
        last   = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (out_req) begin
                    s_d.state = ST_RUN;
                    s_d.tap   = '0;
                    s_d.base  = newest_next;
                    s_d.phase = out_phase;
                    clr       = 1'b1;
                end
            end
            ST_RUN: begin
                acc_en = 1'b1;
                if (s_q.tap == TAP_BITS'(TAPS - 1)) begin
                    last = 1'b1;
                    if (out_req || s_q.pend) begin
                        s_d.tap   = '0;
                        s_d.base  = newest_next;
                        s_d.phase = out_req ? out_phase : s_q.pend_phase;
                        s_d.pend  = 1'b0;
                        clr       = 1'b1;
                    end else begin
                        s_d.state = ST_IDLE;
                    end
                end else begin
                    s_d.tap = s_q.tap + TAP_BITS'(1);
                    if (out_req) begin
                        s_d.pend       = 1'b1;
                        s_d.pend_phase = out_phase;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_pend_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN && s_q.tap == TAP_BITS'(TAPS - 1) && s_q.pend)
        |=> (s_q.state == ST_RUN && s_q.tap == '0))
        else $error("held request not started at end of run");

    p_coef_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN) |-> (coef >= 0 && coef <= HALF))
        else $error("coefficient outside prototype range");

    p_base_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_RUN && s_q.tap != TAP_BITS'(TAPS - 1)) |=> $stable(s_q.base))
        else $error("read base moved during a run");
endmodule

// File: tb/phase_interp_tb_top.sv
module phase_interp_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS       = 64;
    localparam int PROTO_LEN  = 16384;
    localparam int NVEC       = 8;
    // {seed[15:0], phase[15:0]}
    localparam logic [31:0] VECS [NVEC] = '{
        32'h0001_0000, 32'h0002_FF00, 32'h0003_00FF, 32'h0004_8080,
        32'h0005_FFFF, 32'h0006_1234, 32'h0007_7F01, 32'h0008_C0C0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic        out_req = 1'b0;
    logic [15:0] out_phase = '0;
    logic        out_valid;
    logic [23:0] out_sample;

    int checks = 0;
    int errors = 0;
    int hm [TAPS];
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_interp dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_req(out_req), .out_phase(out_phase),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sx24(input int v);
        logic [23:0] t;
        t = 24'(v);
        return int'($signed(t));
    endfunction

    function automatic int gen(input int seed, input int k);
        return sx24(k * 40503 * seed + seed * 977 + 12345);
    endfunction

    function automatic int proto(input int n);
        if (n < PROTO_LEN / 2) return n + 1;
        return PROTO_LEN - n;
    endfunction

    function automatic int coef_m(input int t, input int ph);
        int n, d, u;
        n = t * 256 + (ph >> 8);
        u = ph & 255;
        d = proto(n + 1) - proto(n);
        return proto(n) + ((d * u) >>> 8);
    endfunction

    function automatic longint model(input int ph);
        longint s, r;
        s = 0;
        for (int t = 0; t < TAPS; t++) s += longint'(hm[t]) * longint'(coef_m(t, ph));
        r = (s + 64'sd131072) >>> 18;
        if (r > 8388607)  r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    function automatic longint sout();
        return longint'($signed(out_sample));
    endfunction

    // one cycle of stimulus, driven at a falling edge
    task automatic cycle_in(input bit v, input int x, input bit r, input int ph);
        in_valid  = v;
        in_sample = 24'(x);
        out_req   = r;
        out_phase = 16'(ph);
        if (v) begin
            for (int a = TAPS - 1; a > 0; a--) hm[a] = hm[a-1];
            hm[0] = sx24(x);
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_req  = 1'b0;
    endtask

    task automatic wait_valid(output int lat);
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic wait_next(output int lat);
        @(negedge clk);
        lat = 1;
        while (!out_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic fill(input int seed);
        for (int k = 0; k < TAPS; k++) cycle_in(1'b1, gen(seed, k), 1'b0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lat;
        longint e1, e2;
        for (int a = 0; a < TAPS; a++) hm[a] = 0;
        repeat (3) @(negedge clk);
        check("R8 out_valid after reset", longint'(out_valid), 0);
        check("R8 out_sample after reset", sout(), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R8: empty history yields zero
        cycle_in(1'b0, 0, 1'b1, 16'h4000);
        wait_valid(lat);
        check("R1 latency on empty history", lat, 64);
        check("R8 empty history output", sout(), 0);

        // vector table: history fill, then one request
        for (int v = 0; v < NVEC; v++) begin
            int seed, ph;
            string tag;
            seed = int'(VECS[v][31:16]);
            ph   = int'(VECS[v][15:0]);
            tag  = ((ph & 255) == 0) ? "R2/R4 vector" : "R3/R4 vector";
            fill(seed);
            e1 = model(ph);
            cycle_in(1'b0, 0, 1'b1, ph);
            wait_valid(lat);
            check({tag, " value"}, sout(), e1);
            check("R5 vector latency", lat, 64);
        end

        // R9: saturation at both limits
        for (int k = 0; k < TAPS; k++) cycle_in(1'b1, 8388607, 1'b0, 0);
        cycle_in(1'b0, 0, 1'b1, 16'h2000);
        wait_valid(lat);
        check("R9 positive limit", sout(), 8388607);
        for (int k = 0; k < TAPS; k++) cycle_in(1'b1, -8388608, 1'b0, 0);
        cycle_in(1'b0, 0, 1'b1, 16'h2000);
        wait_valid(lat);
        check("R9 negative limit", sout(), -8388608);

        // R6/R7: write and held request during a run
        fill(21);
        e1 = model(16'h3355);
        cycle_in(1'b0, 0, 1'b1, 16'h3355);
        repeat (5) cycle_in(1'b0, 0, 1'b0, 0);
        cycle_in(1'b1, 7000000, 1'b0, 0);
        repeat (5) cycle_in(1'b0, 0, 1'b0, 0);
        e2 = model(16'hA0F3);
        cycle_in(1'b0, 0, 1'b1, 16'hA0F3);
        wait_valid(lat);
        check("R7 write during run ignored", sout(), e1);
        wait_next(lat);
        check("R6 held request latency", lat, 64);
        check("R6 held request value", sout(), e2);

        // R6: newer held request replaces older
        fill(33);
        e1 = model(16'h1111);
        e2 = model(16'hEE22);
        cycle_in(1'b0, 0, 1'b1, 16'h1111);
        repeat (3) cycle_in(1'b0, 0, 1'b0, 0);
        cycle_in(1'b0, 0, 1'b1, 16'h5A5A);
        repeat (3) cycle_in(1'b0, 0, 1'b0, 0);
        cycle_in(1'b0, 0, 1'b1, 16'hEE22);
        wait_valid(lat);
        check("R6 first of replaced pair", sout(), e1);
        wait_next(lat);
        check("R6 replacing phase used", sout(), e2);
        begin
            int extra;
            extra = 0;
            for (int c = 0; c < 80; c++) begin
                @(negedge clk);
                if (out_valid) extra++;
            end
            check("R6 replaced request dropped", extra, 0);
        end

        // R7: write on the accepting edge is included
        fill(47);
        cycle_in(1'b1, -5000000, 1'b1, 16'h0080);
        e1 = model(16'h0080);
        wait_valid(lat);
        check("R7 same-edge write included", sout(), e1);
        check("R5 same-edge latency", lat, 64);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule